// File: doc/BRIEF.md
# Triple-Mode Synthesizer Programming Interface

This block holds the programming word for an integer-N frequency synthesizer: a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler enable. It also holds an 8-bit enhancement word that controls power-down, continuous counter load, a test route to a data-out pin and a monitor output disable. Two strap pins choose how the word arrives. In serial mode a bit stream is clocked in under a load strobe. In parallel mode an 8-bit bus is written in three sections by separate strobes. In direct mode the divider fields come straight from pins.

The 20-bit divider word is double buffered. Writes land in a primary register, and a hop strobe (or, in serial mode, the rising edge of the load strobe) copies it into a secondary register. A level input chooses which of the two drives the counters, so a radio can stage the next channel and switch between two channels with one pin. Every strobe, the serial clock and the data that goes with them pass through a synchronizer of `SYNC_STAGES` flops on the system clock, and edges are found after synchronization. Each strobe level and each data value must therefore be held for at least `SYNC_STAGES + 1` system clocks.

The interface carries no data stream with flow control. All pins are plain control levels, and the divider outputs are combinational views of the registers and the mode pins.

Top module: `synth_prog_ctrl`

## Requirements
- R1: With `mode_direct` = 1, the divider outputs follow the pins: `div_r` = {2'b00, `pin_r`}, `div_m` = {2'b00, `pin_m`}, `div_a` = `pin_a`, `div_pre_en` = `pin_pre_en`. The top two bits of R and M are therefore always zero.
- R2: In serial mode (`mode_direct` = 0, `mode_serial` = 1), while `sload` and `ewr` are both low, each rising edge of `sck` shifts `sdi` into the primary word, first bit at the top. After 20 bits the word reads, from first to last: R5, R4, M8, M7, prescaler enable, M6..M0, R3..R0, A3..A0.
- R3: The secondary word takes a copy of the primary word on a rising edge of `hop` (serial or parallel mode) or of `sload` (serial mode). At no other time does it change. A falling edge of `sload` does not copy.
- R4: In parallel mode (both straps low), a rising edge of `wr_mlo` loads `pbus[7]` into the prescaler enable and `pbus[6:0]` into M6..M0. A rising edge of `wr_mhi` loads `pbus[3:0]` into R5, R4, M8, M7 in that order. A rising edge of `wr_ra` loads `pbus[7:4]` into R3..R0 and `pbus[3:0]` into A3..A0.
- R5: Outside direct mode, `use_primary` = 1 routes the primary word to the divider outputs and `use_primary` = 0 routes the secondary word.
- R6: In serial mode, while `ewr` is high and `sload` is low, rising `sck` edges shift `sdi` into a shadow enhancement word. `enh_q` and the primary word do not change until `ewr` falls. On that falling edge `enh_q` takes the shadow value.
- R7: In parallel mode, a rising edge of `ewr` loads `pbus` into `enh_q`.
- R8: Bits 2..0 of `enh_q` always read zero, whatever was written.
- R9: The enhancement functions act only while `enh_en_n` is low: `pwr_down` = `enh_q[3]`, `load_cont` = `enh_q[4]`, `mon_off` = `enh_q[7]`. While `enh_en_n` is high, all function outputs are low.
- R10: `dout_msel` = `enh_q[5]` and `dout_presc` = `enh_q[6]` (both gated as in R9). When both bits are set, only `dout_msel` is asserted.
- R11: After reset the primary, secondary and enhancement words are all zero.
- R12: In direct mode all strobes are ignored. The primary and secondary words keep their values, as seen after returning to parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_direct | input | 1 | Strap: 1 selects direct mode |
| mode_serial | input | 1 | Strap: with mode_direct low, 1 selects serial mode and 0 selects parallel mode |
| sck | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data |
| sload | input | 1 | Serial load strobe; shifting is enabled while it is low, and its rising edge copies primary to secondary |
| ewr | input | 1 | Enhancement strobe |
| hop | input | 1 | Hop strobe: its rising edge copies primary to secondary |
| wr_mlo | input | 1 | Parallel strobe for prescaler enable and M6..M0 |
| wr_mhi | input | 1 | Parallel strobe for R5, R4, M8, M7 |
| wr_ra | input | 1 | Parallel strobe for R3..R0 and A3..A0 |
| pbus | input | 8 | Parallel data bus |
| use_primary | input | 1 | 1: counters use the primary word; 0: counters use the secondary word |
| enh_en_n | input | 1 | Active-low enable for the enhancement functions |
| pin_pre_en | input | 1 | Direct-mode prescaler enable |
| pin_m | input | 7 | Direct-mode M6..M0 |
| pin_r | input | 4 | Direct-mode R3..R0 |
| pin_a | input | 4 | Direct-mode A3..A0 |
| div_r | output | 6 | Reference divide value to the counters |
| div_m | output | 9 | Main divide value to the counters |
| div_a | output | 4 | Swallow count to the counters |
| div_pre_en | output | 1 | Prescaler enable to the counters |
| enh_q | output | 8 | Active enhancement word |
| pwr_down | output | 1 | Power-down request |
| load_cont | output | 1 | Continuous counter load |
| dout_msel | output | 1 | Route modulus select to data-out |
| dout_presc | output | 1 | Route raw prescaler output to data-out |
| mon_off | output | 1 | Disable the divider monitor outputs |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This lengthens the path from a pin edge to a register update to four clocks. It shows that the data pipeline stays aligned with its strobe at a depth other than the default, and that results do not depend on a fixed latency: the bench samples only after a hold time of six clocks. All other widths come from the fixed 20-bit frame. The parallel vector table covers all-zero and all-one words, as well as patterns that separate every field boundary, both before and after a hop.

// File: rtl/prog_pkg.sv
package prog_pkg;
  localparam int FRAME_W   = 20;
  localparam int ENH_W     = 8;
  localparam int BUS_W     = 8;
  localparam int R_W       = 6;
  localparam int M_W       = 9;
  localparam int A_W       = 4;
  localparam int PIN_M_W   = 7;
  localparam int PIN_R_W   = 4;

  // bit positions of the frame; the serial order depends on them
  localparam int F_RHI_LSB = 18;
  localparam int F_MHI_LSB = 16;
  localparam int F_PRE     = 15;
  localparam int F_MLO_LSB = 8;
  localparam int F_RLO_LSB = 4;
  localparam int F_A_LSB   = 0;

  // enhancement bit functions
  localparam int E_PWR     = 3;
  localparam int E_LOAD    = 4;
  localparam int E_MSEL    = 5;
  localparam int E_PRESC   = 6;
  localparam int E_MOFF    = 7;
  localparam int E_RSV_W   = 3;

  // synchronized strobe indices
  localparam int ST_SCK    = 0;
  localparam int ST_SLOAD  = 1;
  localparam int ST_EWR    = 2;
  localparam int ST_HOP    = 3;
  localparam int ST_MLO    = 4;
  localparam int ST_MHI    = 5;
  localparam int ST_RA     = 6;
  localparam int ST_N      = 7;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } prog_mode_e;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pre_en;
  } div_cfg_t;
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/prog_divreg.sv
module prog_divreg
  import prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  prog_mode_e         mode,
  input  logic               sck_rise,
  input  logic               sdi,
  input  logic               sload_lvl,
  input  logic               sload_rise,
  input  logic               ewr_lvl,
  input  logic               hop_rise,
  input  logic               mlo_rise,
  input  logic               mhi_rise,
  input  logic               ra_rise,
  input  logic [BUS_W-1:0]   pbus,
  output logic [FRAME_W-1:0] prim_q,
  output logic [FRAME_W-1:0] sec_q
);
  logic copy_now;

  assign copy_now = (mode != MODE_DIR) &&
                    (hop_rise || (mode == MODE_SER && sload_rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      unique case (mode)
        MODE_SER: begin
          if (sck_rise && !sload_lvl && !ewr_lvl)
            prim_q <= {prim_q[FRAME_W-2:0], sdi};
        end
        MODE_PAR: begin
          if (mlo_rise) prim_q[F_PRE:F_MLO_LSB]       <= pbus;
          if (mhi_rise) prim_q[FRAME_W-1:F_MHI_LSB]   <= pbus[3:0];
          if (ra_rise)  prim_q[F_MLO_LSB-1:F_A_LSB]   <= pbus;
        end
        default: ;
      endcase
      if (copy_now) sec_q <= prim_q;
    end
  end
endmodule

// File: rtl/prog_enhreg.sv
module prog_enhreg
  import prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  prog_mode_e       mode,
  input  logic             sck_rise,
  input  logic             sdi,
  input  logic             sload_lvl,
  input  logic             ewr_lvl,
  input  logic             ewr_rise,
  input  logic             ewr_fall,
  input  logic [BUS_W-1:0] pbus,
  output logic [ENH_W-1:0] enh_q
);
  logic [ENH_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      enh_q  <= '0;
    end else begin
      if (mode == MODE_SER && sck_rise && ewr_lvl && !sload_lvl)
        shadow <= {shadow[ENH_W-2:0], sdi};
      if (mode == MODE_SER && ewr_fall)
        enh_q <= {shadow[ENH_W-1:E_RSV_W], {E_RSV_W{1'b0}}};
      else if (mode == MODE_PAR && ewr_rise)
        enh_q <= {pbus[ENH_W-1:E_RSV_W], {E_RSV_W{1'b0}}};
    end
  end
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_direct,
  input  logic               mode_serial,
  input  logic               sck,
  input  logic               sdi,
  input  logic               sload,
  input  logic               ewr,
  input  logic               hop,
  input  logic               wr_mlo,
  input  logic               wr_mhi,
  input  logic               wr_ra,
  input  logic [7:0]         pbus,
  input  logic               use_primary,
  input  logic               enh_en_n,
  input  logic               pin_pre_en,
  input  logic [6:0]         pin_m,
  input  logic [3:0]         pin_r,
  input  logic [3:0]         pin_a,
  output logic [5:0]         div_r,
  output logic [8:0]         div_m,
  output logic [3:0]         div_a,
  output logic               div_pre_en,
  output logic [7:0]         enh_q,
  output logic               pwr_down,
  output logic               load_cont,
  output logic               dout_msel,
  output logic               dout_presc,
  output logic               mon_off
);
  localparam int DAT_W = BUS_W + 1;

  prog_mode_e         mode;
  logic [ST_N-1:0]    strb_raw, strb_s, strb_d, strb_rise, strb_fall;
  logic [DAT_W-1:0]   dat_s;
  logic [BUS_W-1:0]   pbus_s;
  logic               sdi_s;
  logic [FRAME_W-1:0] prim_w, sec_w, sel_w;
  logic               enh_on;

  assign mode = mode_direct ? MODE_DIR : (mode_serial ? MODE_SER : MODE_PAR);

  assign strb_raw = {wr_ra, wr_mhi, wr_mlo, hop, ewr, sload, sck};

  prog_sync #(.W(ST_N), .STAGES(SYNC_STAGES)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );

  prog_sync #(.W(DAT_W), .STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d({sdi, pbus}), .q(dat_s)
  );

  assign sdi_s  = dat_s[DAT_W-1];
  assign pbus_s = dat_s[BUS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_d <= '0;
    else        strb_d <= strb_s;
  end

  for (genvar g = 0; g < ST_N; g++) begin : g_edge
    assign strb_rise[g] =  strb_s[g] & ~strb_d[g];
    assign strb_fall[g] = ~strb_s[g] &  strb_d[g];
  end

  prog_divreg u_divreg (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sck_rise(strb_rise[ST_SCK]), .sdi(sdi_s),
    .sload_lvl(strb_s[ST_SLOAD]), .sload_rise(strb_rise[ST_SLOAD]),
    .ewr_lvl(strb_s[ST_EWR]), .hop_rise(strb_rise[ST_HOP]),
    .mlo_rise(strb_rise[ST_MLO]), .mhi_rise(strb_rise[ST_MHI]),
    .ra_rise(strb_rise[ST_RA]), .pbus(pbus_s),
    .prim_q(prim_w), .sec_q(sec_w)
  );

  prog_enhreg u_enhreg (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .sck_rise(strb_rise[ST_SCK]), .sdi(sdi_s),
    .sload_lvl(strb_s[ST_SLOAD]), .ewr_lvl(strb_s[ST_EWR]),
    .ewr_rise(strb_rise[ST_EWR]), .ewr_fall(strb_fall[ST_EWR]),
    .pbus(pbus_s), .enh_q(enh_q)
  );

  assign sel_w = use_primary ? prim_w : sec_w;

  always_comb begin
    if (mode == MODE_DIR) begin
      div_r      = {2'b00, pin_r};
      div_m      = {2'b00, pin_m};
      div_a      = pin_a;
      div_pre_en = pin_pre_en;
    end else begin
      div_r      = {sel_w[FRAME_W-1:F_RHI_LSB], sel_w[F_MLO_LSB-1:F_RLO_LSB]};
      div_m      = {sel_w[F_RHI_LSB-1:F_MHI_LSB], sel_w[F_PRE-1:F_MLO_LSB]};
      div_a      = sel_w[F_RLO_LSB-1:F_A_LSB];
      div_pre_en = sel_w[F_PRE];
    end
  end

  assign enh_on     = ~enh_en_n;
  assign pwr_down   = enh_on & enh_q[E_PWR];
  assign load_cont  = enh_on & enh_q[E_LOAD];
  assign mon_off    = enh_on & enh_q[E_MOFF];
  assign dout_msel  = enh_on & enh_q[E_MSEL];
  assign dout_presc = enh_on & enh_q[E_PRESC] & ~enh_q[E_MSEL];
endmodule

// File: rtl/prog_ctrl_chk.sv
module prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_direct,
  input logic       enh_en_n,
  input logic [5:0] div_r,
  input logic [8:0] div_m,
  input logic [7:0] enh_q,
  input logic       pwr_down,
  input logic       load_cont,
  input logic       dout_msel,
  input logic       dout_presc,
  input logic       mon_off,
  input logic       ewr_s,
  input logic       ewr_d
);
  // R1
  direct_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> (div_r[5:4] == 2'b00 && div_m[8:7] == 2'b00));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_q[2:0] == 3'b000);

  // R9
  enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_en_n |-> !(pwr_down || load_cont || dout_msel || dout_presc || mon_off));

  // R10
  dout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dout_msel, dout_presc}) <= 1);

  // R6
  enh_change_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(enh_q) |-> $past(ewr_s != ewr_d));
endmodule

bind synth_prog_ctrl prog_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .enh_en_n(enh_en_n),
  .div_r(div_r), .div_m(div_m), .enh_q(enh_q), .pwr_down(pwr_down),
  .load_cont(load_cont), .dout_msel(dout_msel), .dout_presc(dout_presc),
  .mon_off(mon_off), .ewr_s(strb_s[2]), .ewr_d(strb_d[2])
);

// File: tb/synth_prog_ctrl_bench.sv
module synth_prog_ctrl_bench;
  localparam int HOLD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_direct = 0, mode_serial = 0, sck = 0, sdi = 0, sload = 0, ewr = 0, hop = 0;
  logic wr_mlo = 0, wr_mhi = 0, wr_ra = 0, use_primary = 1, enh_en_n = 1;
  logic [7:0] pbus = '0;
  logic pin_pre_en = 0;
  logic [6:0] pin_m = '0;
  logic [3:0] pin_r = '0, pin_a = '0;
  logic [5:0] div_r;
  logic [8:0] div_m;
  logic [3:0] div_a;
  logic div_pre_en, pwr_down, load_cont, dout_msel, dout_presc, mon_off;
  logic [7:0] enh_q;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  synth_prog_ctrl #(.SYNC_STAGES(3)) u_synth_prog_ctrl (.*);

  // {mlo[7:0], mhi[3:0], ra[7:0], exp r[5:0], m[8:0], a[3:0], pre}
  localparam logic [39:0] VEC [4] = '{
    40'h00_0_00_00000,
    40'hFF_F_FF_FFFFF,
    40'h85_9_3C_8D0B9,
    40'h2A_6_A7_6A54E
  };

  function automatic logic [19:0] cfg();
    return {div_r, div_m, div_a, div_pre_en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: hop = 1;  1: wr_mlo = 1;  2: wr_mhi = 1;  3: wr_ra = 1;
      4: sload = 1; 5: ewr = 1;
      default: ;
    endcase
    wait_hold();
    hop = 0; wr_mlo = 0; wr_mhi = 0; wr_ra = 0; sload = 0; ewr = 0;
    wait_hold();
  endtask

  task automatic par_write(input int which, input logic [7:0] d);
    pbus = d; wait_hold(); pulse(which);
  endtask

  task automatic ser_bit(input logic b);
    sdi = b; wait_hold(); sck = 1; wait_hold(); sck = 0; wait_hold();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [19:0] prev;
    logic [19:0] sword;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wait_hold();
    // R11: reset state
    check("R11 primary after reset", cfg(), 20'h0);
    use_primary = 0; wait_hold();
    check("R11 secondary after reset", cfg(), 20'h0);
    check("R11 enh after reset", enh_q, 8'h00);
    use_primary = 1;

    // parallel vectors: R4, R5, R3
    prev = 20'h0;
    foreach (VEC[i]) begin
      par_write(1, VEC[i][39:32]);
      par_write(2, {4'h0, VEC[i][31:28]});
      par_write(3, VEC[i][27:20]);
      use_primary = 1; wait_hold();
      check("R4 R5 primary view", cfg(), VEC[i][19:0]);
      use_primary = 0; wait_hold();
      check("R3 secondary before hop", cfg(), prev);
      pulse(0);
      check("R3 R5 secondary after hop", cfg(), VEC[i][19:0]);
      prev = VEC[i][19:0];
    end

    // stage a different primary, then R12 in direct mode
    use_primary = 1;
    par_write(1, 8'h00);
    check("R4 partial write", cfg(), {6'h1A, 9'h100, 4'h7, 1'b0});
    pin_pre_en = 1; pin_m = 7'h7F; pin_r = 4'hF; pin_a = 4'h5;
    mode_direct = 1; wait_hold();
    check("R1 direct pins", cfg(), {6'h0F, 9'h07F, 4'h5, 1'b1});
    par_write(3, 8'h00);
    pulse(0);
    pulse(5);
    mode_direct = 0; wait_hold();
    check("R12 primary kept", cfg(), {6'h1A, 9'h100, 4'h7, 1'b0});
    check("R12 enh kept", enh_q, 8'h00);
    use_primary = 0; wait_hold();
    check("R12 secondary kept", cfg(), 20'h6A54E);

    // serial frame R2, R3
    mode_serial = 1; use_primary = 1; wait_hold();
    sword = 20'hA5C3E;
    for (int b = 19; b >= 0; b--) ser_bit(sword[b]);
    check("R2 serial primary", cfg(), {6'h23, 9'h15C, 4'hE, 1'b0});
    use_primary = 0; wait_hold();
    check("R3 no copy before sload", cfg(), 20'h6A54E);
    sload = 1; wait_hold();
    check("R3 copy on sload rise", cfg(), {6'h23, 9'h15C, 4'hE, 1'b0});
    sload = 0; wait_hold();

    // serial enhancement R6, R8
    ewr = 1; wait_hold();
    for (int b = 0; b < 8; b++) ser_bit(1'b1);
    check("R6 enh unchanged while ewr high", enh_q, 8'h00);
    use_primary = 1; wait_hold();
    check("R6 primary untouched", cfg(), {6'h23, 9'h15C, 4'hE, 1'b0});
    ewr = 0; wait_hold();
    check("R6 R8 enh on ewr fall", enh_q, 8'hF8);

    // R9, R10 gating and priority
    check("R9 gated off", {pwr_down, load_cont, mon_off, dout_msel, dout_presc}, 5'b0);
    enh_en_n = 0; wait_hold();
    check("R9 functions on", {pwr_down, load_cont, mon_off}, 3'b111);
    check("R10 msel priority", {dout_msel, dout_presc}, 2'b10);

    // parallel enhancement R7, R10
    mode_serial = 0; wait_hold();
    par_write(5, 8'h47);
    check("R7 R8 parallel enh", enh_q, 8'h40);
    check("R10 prescaler route", {dout_msel, dout_presc, pwr_down}, 3'b010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule